// File: doc/BRIEF.md
# Weighted Receive/Transmit Bus Arbiter

This block decides which of two DMA engines, one for receive and one for transmit, owns a single shared bus master. The grant is registered and stays with its owner until that owner pulses `done_i`. A new decision is made only when the bus is idle or in the cycle of a done pulse.

There are two modes. In weighted cyclic mode, a 2-bit ratio setting lets the receive side win up to K contested decisions in a row, where K is 1 to 4. After that, the transmit side gets the next one. In fixed-priority mode, receive wins every contest and the ratio setting has no effect. A synchronous soft reset drops the grant and clears the weighting count.

Top module: `rtarb_top`

## Requirements
- R1: While `rst_ni` is low, both grants are 0. This holds immediately, without waiting for a clock edge, even if a grant was active.
- R2: `rx_gnt_o` and `tx_gnt_o` are never 1 in the same cycle.
- R3: A grant changes only at a clock edge. A decision takes effect at the edge that samples it. While a grant is active and `done_i` is 0, the grant holds whatever the requests do.
- R4: In cyclic mode (`fixed_prio_i`=0) with both sides requesting at every decision, receive is granted K times and then transmit once. K = `ratio_i`+1, so 00 gives 1:1, 01 gives 2:1, 10 gives 3:1 and 11 gives 4:1. The weighting count returns to zero on the transmit grant.
- R5: In cyclic mode, a side that requests alone is granted. Such a decision leaves the weighting count unchanged.
- R6: In fixed mode (`fixed_prio_i`=1), receive wins whenever both sides request, for any `ratio_i` value.
- R7: `soft_rst_i`=1 drops any grant at the next edge and clears the weighting count.
- R8: A decision with no request leaves both grants at 0. A `done_i` pulse while idle has no effect on the grants.
- R9: Decisions taken in fixed mode do not change the weighting count. When cyclic mode returns, the count resumes from its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous clear of grant and weighting count |
| rx_req_i | input | 1 | Receive side requests the bus |
| tx_req_i | input | 1 | Transmit side requests the bus |
| done_i | input | 1 | Current owner finishes its transaction |
| fixed_prio_i | input | 1 | 1 selects fixed receive priority, 0 selects weighted cyclic mode |
| ratio_i | input | RATIO_W | Receive wins per transmit win, minus one |
| rx_gnt_o | output | 1 | Receive side owns the bus |
| tx_gnt_o | output | 1 | Transmit side owns the bus |

## Verification
Both sides request continuously with a done pulse every cycle. This is done at each of the four ratio settings, and each setting must produce its own receive-to-transmit pattern. Runs of a single requester are placed between contested decisions. If such a run advanced the count, transmit would be granted too early.

Toggling into fixed mode halfway through a weighted sequence separates a count that is held from one that is cleared or advanced. A count built up before a soft reset separates a reset that clears the count from one that only drops the grant. Cycles with `done_i` low show that requests cannot move an active grant.

// File: rtl/rtarb_pkg.sv
package rtarb_pkg;
  typedef struct packed {
    logic tx;
    logic rx;
  } gnt_t;

  localparam gnt_t GNT_NONE = '{tx: 1'b0, rx: 1'b0};
  localparam gnt_t GNT_RX   = '{tx: 1'b0, rx: 1'b1};
  localparam gnt_t GNT_TX   = '{tx: 1'b1, rx: 1'b0};
endpackage

// File: rtl/rtarb_ratio_cnt.sv
module rtarb_ratio_cnt #(
  parameter int unsigned MAX_K = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic             wrap_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || wrap_i)    cnt_q <= '0;
    else if (adv_i && (cnt_q < CNT_W'(MAX_K))) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_K)); // R4
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R7
endmodule

// File: rtl/rtarb_pick.sv
module rtarb_pick
  import rtarb_pkg::*;
#(
  parameter int unsigned RATIO_W = 2,
  parameter int unsigned CNT_W   = 3
) (
  input  logic               rx_req_i,
  input  logic               tx_req_i,
  input  logic               fixed_prio_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output gnt_t               pick_o,
  output logic               adv_o,
  output logic               wrap_o
);
  logic [CNT_W-1:0] k_lim;
  logic             contest;

  assign k_lim   = CNT_W'(ratio_i) + CNT_W'(1);
  assign contest = rx_req_i && tx_req_i;

  always_comb begin
    pick_o = GNT_NONE;
    adv_o  = 1'b0;
    wrap_o = 1'b0;
    if (contest) begin
      if (fixed_prio_i) begin
        pick_o = GNT_RX;
      end else if (cnt_i >= k_lim) begin
        pick_o = GNT_TX;
        wrap_o = 1'b1;
      end else begin
        pick_o = GNT_RX;
        adv_o  = 1'b1;
      end
    end else if (rx_req_i) begin
      pick_o = GNT_RX;
    end else if (tx_req_i) begin
      pick_o = GNT_TX;
    end
  end
endmodule

// File: rtl/rtarb_gnt_reg.sv
module rtarb_gnt_reg
  import rtarb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic done_i,
  input  gnt_t pick_i,
  output gnt_t gnt_o,
  output logic arb_o
);
  gnt_t gnt_q;
  logic busy;

  assign busy  = gnt_q.rx || gnt_q.tx;
  assign arb_o = !busy || done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         gnt_q <= GNT_NONE;
    else if (soft_rst_i) gnt_q <= GNT_NONE;
    else if (arb_o)      gnt_q <= pick_i;
  end

  assign gnt_o = gnt_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gnt_q.tx, gnt_q.rx})); // R2
  AST_GNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done_i && !soft_rst_i) |=> $stable(gnt_q)); // R3
  AST_SOFT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !gnt_q.rx && !gnt_q.tx); // R7
endmodule

// File: rtl/rtarb_top.sv
module rtarb_top
  import rtarb_pkg::*;
#(
  parameter int unsigned RATIO_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               rx_req_i,
  input  logic               tx_req_i,
  input  logic               done_i,
  input  logic               fixed_prio_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               rx_gnt_o,
  output logic               tx_gnt_o
);
  localparam int unsigned MAX_K = 1 << RATIO_W;
  localparam int unsigned CNT_W = $clog2(MAX_K + 1);

  gnt_t             pick;
  gnt_t             gnt;
  logic             arb;
  logic             adv;
  logic             wrap;
  logic [CNT_W-1:0] cnt;

  rtarb_pick #(.RATIO_W(RATIO_W), .CNT_W(CNT_W)) i_pick (
    .rx_req_i    (rx_req_i),
    .tx_req_i    (tx_req_i),
    .fixed_prio_i(fixed_prio_i),
    .ratio_i     (ratio_i),
    .cnt_i       (cnt),
    .pick_o      (pick),
    .adv_o       (adv),
    .wrap_o      (wrap)
  );

  rtarb_gnt_reg i_gnt_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst_i),
    .done_i    (done_i),
    .pick_i    (pick),
    .gnt_o     (gnt),
    .arb_o     (arb)
  );

  // count moves only on a taken decision
  rtarb_ratio_cnt #(.MAX_K(MAX_K), .CNT_W(CNT_W)) i_ratio_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (soft_rst_i),
    .adv_i (arb && adv),
    .wrap_i(arb && wrap),
    .cnt_o (cnt)
  );

  assign rx_gnt_o = gnt.rx;
  assign tx_gnt_o = gnt.tx;

  AST_FIXED_RX_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb && fixed_prio_i && rx_req_i && !soft_rst_i) |=> rx_gnt_o); // R6
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb && !rx_req_i && !tx_req_i) |=> !rx_gnt_o && !tx_gnt_o); // R8
  AST_LONE_REQ_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb && (rx_req_i != tx_req_i) && !soft_rst_i) |=> $stable(cnt)); // R5
  AST_FIXED_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fixed_prio_i && !soft_rst_i) |=> $stable(cnt)); // R9
endmodule

// File: tb/test_rtarb_top.sv
module test_rtarb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC       = 42;

  // {id[3:0], soft_rst, rx_req, tx_req, done, fixed, ratio[1:0], exp{tx,rx}}
  localparam logic [12:0] VEC [NVEC] = '{
    13'b0100_0111_0_00_01, 13'b0100_0111_0_00_10, 13'b0100_0111_0_00_01, 13'b0100_0111_0_00_10,
    13'b0100_0111_0_01_01, 13'b0100_0111_0_01_01, 13'b0100_0111_0_01_10,
    13'b0100_0111_0_01_01, 13'b0100_0111_0_01_01, 13'b0100_0111_0_01_10,
    13'b0100_0111_0_10_01, 13'b0100_0111_0_10_01, 13'b0100_0111_0_10_01, 13'b0100_0111_0_10_10,
    13'b0100_0111_0_11_01, 13'b0100_0111_0_11_01, 13'b0100_0111_0_11_01, 13'b0100_0111_0_11_01,
    13'b0100_0111_0_11_10,
    13'b0101_0111_0_01_01, 13'b0101_0101_0_01_01, 13'b0101_0101_0_01_01, 13'b0101_0011_0_01_10,
    13'b0101_0111_0_01_01, 13'b0101_0111_0_01_10,
    13'b1001_0111_0_00_01, 13'b0110_0111_1_11_01, 13'b0110_0111_1_00_01, 13'b1001_0011_1_00_10,
    13'b1001_0111_0_00_10,
    13'b0011_0100_0_00_10, 13'b0011_0100_0_00_10, 13'b0011_0101_0_00_01, 13'b0011_0110_0_00_01,
    13'b1000_0001_0_00_00, 13'b1000_0000_0_00_00, 13'b1000_0010_0_00_10,
    13'b0111_0111_0_11_01, 13'b0111_0111_0_11_01, 13'b0111_1110_0_11_00, 13'b0111_0111_0_00_01,
    13'b0111_0111_0_00_10
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic       rx_req_i = 1'b0;
  logic       tx_req_i = 1'b0;
  logic       done_i = 1'b0;
  logic       fixed_prio_i = 1'b0;
  logic [1:0] ratio_i = 2'b00;
  logic       rx_gnt_o;
  logic       tx_gnt_o;
  int         n_chk = 0;
  int         n_err = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  rtarb_top #(.RATIO_W(2)) i_rtarb_top (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .rx_req_i    (rx_req_i),
    .tx_req_i    (tx_req_i),
    .done_i      (done_i),
    .fixed_prio_i(fixed_prio_i),
    .ratio_i     (ratio_i),
    .rx_gnt_o    (rx_gnt_o),
    .tx_gnt_o    (tx_gnt_o)
  );

  function automatic string tag_of(logic [3:0] id);
    case (id)
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual {tx,rx}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_r2();
    chk("R2", {1'b0, tx_gnt_o && rx_gnt_o}, 2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #(CLK_PERIOD * 2 + 1ns);
    chk("R1", {tx_gnt_o, rx_gnt_o}, 2'b00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      {soft_rst_i, rx_req_i, tx_req_i, done_i, fixed_prio_i, ratio_i} = VEC[i][8:2];
      @(posedge clk_i);
      #1ns;
      chk(tag_of(VEC[i][12:9]), {tx_gnt_o, rx_gnt_o}, VEC[i][1:0]);
      chk_r2();
    end

    // R1: async reset drops an active grant without a clock edge
    @(negedge clk_i);
    {soft_rst_i, rx_req_i, tx_req_i, done_i, fixed_prio_i, ratio_i} = 7'b0_1_1_1_1_00;
    @(posedge clk_i);
    #1ns;
    chk("R6", {tx_gnt_o, rx_gnt_o}, 2'b01);
    #1ns;
    rst_ni = 1'b0;
    #1ns;
    chk("R1", {tx_gnt_o, rx_gnt_o}, 2'b00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule